// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Serial Peripheral Takeover

This block is one slice of eight general-purpose I/O pins. Software configures it through four byte-wide registers on a small synchronous register bus: an output latch, a direction mask, a pull-enable mask and a pull-polarity mask. For each pin the block drives four pad controls: output value, output enable, pull-up enable and pull-down enable. It also receives one pad input level per pin. Every pad input passes through a two-stage synchroniser. The synchronised levels feed register read-back and the receive paths of the attached peripherals.

Two serial functions can claim pins, and while they do, they override the direction and latch registers. Pins 4 to 7 belong to an SPI engine. Pins 0 to 3 carry two UART channels: each channel's receive line sits on the even pin and its transmit line on the odd pin above it. A pin that its peripheral has not claimed behaves as plain I/O.

Pull resolution turns each pin's polarity bit into separate pull-up and pull-down enables. These are active only while the pin is really an input, which takes any peripheral override into account.

The register bus has no back-pressure. An access with `bus_sel` high completes in the cycle it is presented. Writes land on the next rising edge. Read data is combinational.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, all four registers read 0x00 and every bit of `pad_oe`, `pad_out`, `pad_pu` and `pad_pd` is 0.
- R2: A write with `bus_sel`=1 and `bus_wr`=1 updates the register chosen by `bus_addr` at the next rising clock edge. The address encoding is 0 = output latch, 1 = direction (1 = output), 2 = pull enable, 3 = pull polarity. Direction, pull-enable and pull-polarity registers read back the stored value.
- R3: A read of address 0 returns, for each bit, the latch bit when that pin's direction bit is 1, and the synchronised pad input when it is 0.
- R4: A pad input change is not visible at any synchronised consumer one rising edge later, and is visible two rising edges later.
- R5: On a pin no peripheral claims, `pad_oe` equals the direction bit and `pad_out` equals the latch bit.
- R6: With pull enable set on an input pin, polarity 0 asserts `pad_pu` only and polarity 1 asserts `pad_pd` only. With pull enable clear, or on a pin driving out, both stay 0.
- R7: When `uart_tx_en[c]` is 1, pin 2c+1 has `pad_oe`=1 and `pad_out`=`uart_txd[c]`, regardless of the direction and latch registers.
- R8: When `uart_rx_en[c]` is 1, pin 2c has `pad_oe`=0 regardless of its direction bit. `uart_rxd[c]` always carries the synchronised level of pin 2c.
- R9: When `spi_en` is 1, pin 4+k (k = 0 slave select, 1 clock, 2 MOSI, 3 MISO) takes `pad_oe` from `spi_oe[k]` and `pad_out` from `spi_out[k]`. `spi_in[k]` always carries the synchronised level of pin 4+k.
- R10: Pull devices follow the effective output enable. A pin forced to input by a peripheral gets its pull, and a pin forced to output by a peripheral gets none.
- R11: An access with `bus_sel`=0, or with `bus_wr`=0, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| spi_en | input | 1 | SPI engine owns pins 7..4 |
| spi_oe | input | 4 | SPI per-pin output enable |
| spi_out | input | 4 | SPI per-pin output value |
| spi_in | output | 4 | Synchronised levels of pins 7..4 |
| uart_tx_en | input | 2 | Transmitter enable per channel |
| uart_txd | input | 2 | Transmit data per channel |
| uart_rx_en | input | 2 | Receiver enable per channel |
| uart_rxd | output | 2 | Synchronised receive levels (pins 2, 0) |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pull-up enables |
| pad_pd | output | 8 | Pull-down enables |

## Verification
A vector table sweeps direction, latch, pull-enable, polarity and pad-input patterns with no peripheral active. Alternating and complementary masks separate the latch path from the pad path in read-back. They also separate pull-up from pull-down and input pins from output pins. Directed patterns then turn on each UART transmitter and receiver and the SPI engine against direction settings that disagree with them. This shows that the override, not the register, decides the pad and the pull. A step on a pad input, sampled after one edge and after two, shows the synchroniser depth.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_LATCH = 2'd0,
    REG_DIR   = 2'd1,
    REG_PEN   = 2'd2,
    REG_PPOL  = 2'd3
  } gpio_reg_e;

  localparam int unsigned REG_AW = 2;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pen_q,
  output logic [W-1:0]      ppol_q
);
  logic wr_hit;
  assign wr_hit = sel & wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pen_q   <= '0;
      ppol_q  <= '0;
    end else if (wr_hit) begin
      unique case (gpio_reg_e'(addr))
        REG_LATCH: latch_q <= wdata;
        REG_DIR:   dir_q   <= wdata;
        REG_PEN:   pen_q   <= wdata;
        REG_PPOL:  ppol_q  <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (gpio_reg_e'(addr))
      REG_LATCH: rdata = (dir_q & latch_q) | (~dir_q & pin_sync);
      REG_DIR:   rdata = dir_q;
      REG_PEN:   rdata = pen_q;
      REG_PPOL:  rdata = ppol_q;
      default:   rdata = '0;
    endcase
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == REG_DIR) |=> (dir_q == $past(wdata)));

  // R11
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && wr)) |=> ($stable(latch_q) && $stable(dir_q) && $stable(pen_q) && $stable(ppol_q)));
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
  parameter int unsigned W       = 8,
  parameter int unsigned SPI_LSB = 4,
  parameter int unsigned SPI_N   = W - SPI_LSB,
  parameter int unsigned UART_N  = SPI_LSB / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      latch_q,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      pen_q,
  input  logic [W-1:0]      ppol_q,
  input  logic              spi_en,
  input  logic [SPI_N-1:0]  spi_oe,
  input  logic [SPI_N-1:0]  spi_out,
  input  logic [UART_N-1:0] tx_en,
  input  logic [UART_N-1:0] txd,
  input  logic [UART_N-1:0] rx_en,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pu,
  output logic [W-1:0]      pad_pd
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i >= SPI_LSB) begin : g_spi
      assign pad_oe[i]  = spi_en ? spi_oe[i-SPI_LSB]  : dir_q[i];
      assign pad_out[i] = spi_en ? spi_out[i-SPI_LSB] : latch_q[i];
    end else if (i % 2 == 1) begin : g_tx
      assign pad_oe[i]  = tx_en[i/2] | dir_q[i];
      assign pad_out[i] = tx_en[i/2] ? txd[i/2] : latch_q[i];
    end else begin : g_rx
      assign pad_oe[i]  = ~rx_en[i/2] & dir_q[i];
      assign pad_out[i] = latch_q[i];
    end
    assign pad_pu[i] = pen_q[i] & ~pad_oe[i] & ~ppol_q[i];
    assign pad_pd[i] = pen_q[i] & ~pad_oe[i] &  ppol_q[i];
  end

  // R6
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  // R10
  pull_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu | pad_pd) & pad_oe) == '0);

  // R7
  uart0_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en[0] |-> (pad_oe[1] && pad_out[1] == txd[0]));

  // R8
  uart0_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en[0] |-> !pad_oe[0]);

  // R9
  spi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> (pad_oe[W-1:SPI_LSB] == spi_oe && pad_out[W-1:SPI_LSB] == spi_out));
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_pkg::*;
#(
  parameter int unsigned PINS        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SPI_LSB     = 4,
  localparam int unsigned SPI_N      = PINS - SPI_LSB,
  localparam int unsigned UART_N     = SPI_LSB / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic              spi_en,
  input  logic [SPI_N-1:0]  spi_oe,
  input  logic [SPI_N-1:0]  spi_out,
  output logic [SPI_N-1:0]  spi_in,
  input  logic [UART_N-1:0] uart_tx_en,
  input  logic [UART_N-1:0] uart_txd,
  input  logic [UART_N-1:0] uart_rx_en,
  output logic [UART_N-1:0] uart_rxd,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd
);
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] latch_q, dir_q, pen_q, ppol_q;

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.W(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pin_sync(pin_sync), .rdata(bus_rdata),
    .latch_q(latch_q), .dir_q(dir_q), .pen_q(pen_q), .ppol_q(ppol_q)
  );

  gpio_pin_ctl #(.W(PINS), .SPI_LSB(SPI_LSB)) u_ctl (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q),
    .pen_q(pen_q), .ppol_q(ppol_q), .spi_en(spi_en), .spi_oe(spi_oe),
    .spi_out(spi_out), .tx_en(uart_tx_en), .txd(uart_txd), .rx_en(uart_rx_en),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  assign spi_in = pin_sync[PINS-1:SPI_LSB];
  for (genvar c = 0; c < UART_N; c++) begin : g_rxd
    assign uart_rxd[c] = pin_sync[2*c];
  end
endmodule

// File: tb/tb_gpio_ovr_port.sv
module tb_gpio_ovr_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic       spi_en = 1'b0;
  logic [3:0] spi_oe = 4'd0, spi_out = 4'd0, spi_in;
  logic [1:0] uart_tx_en = 2'd0, uart_txd = 2'd0, uart_rx_en = 2'd0, uart_rxd;
  logic [7:0] pad_in = 8'd0, pad_out, pad_oe, pad_pu, pad_pd;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_ovr_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_en(spi_en), .spi_oe(spi_oe), .spi_out(spi_out), .spi_in(spi_in),
    .uart_tx_en(uart_tx_en), .uart_txd(uart_txd), .uart_rx_en(uart_rx_en),
    .uart_rxd(uart_rxd), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // {dir, latch, pull enable, polarity, pad_in}
  localparam logic [39:0] VEC [8] = '{
    40'h00_00_00_00_A5, 40'hFF_3C_FF_00_00, 40'h0F_F0_FF_00_C3,
    40'hF0_AA_FF_FF_5A, 40'h55_FF_AA_0F_AA, 40'hAA_0F_55_F0_FF,
    40'h00_FF_F0_33_0F, 40'hC3_81_3C_C3_7E
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), rd);
      chk("R1 reg", rd, 8'h00);
    end
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pulls", pad_pu | pad_pd, 8'h00);

    // R11 ignored accesses
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd_reg(2'd1, rd);
    chk("R11 dir", rd, 8'h00);
    chk("R11 pad_oe", pad_oe, 8'h00);

    // R2 write and read back
    wr_reg(2'd1, 8'h96); rd_reg(2'd1, rd); chk("R2 dir", rd, 8'h96);
    wr_reg(2'd2, 8'h3C); rd_reg(2'd2, rd); chk("R2 pen", rd, 8'h3C);
    wr_reg(2'd3, 8'hE1); rd_reg(2'd3, rd); chk("R2 pol", rd, 8'hE1);

    // Table walk: R3, R5, R6
    foreach (VEC[i]) begin
      logic [7:0] d, l, pe, po, pi;
      {d, l, pe, po, pi} = VEC[i];
      wr_reg(2'd1, d); wr_reg(2'd0, l); wr_reg(2'd2, pe); wr_reg(2'd3, po);
      pad_in = pi;
      settle();
      chk("R5 pad_oe", pad_oe, d);
      chk("R5 pad_out", pad_out, l);
      chk("R6 pad_pu", pad_pu, pe & ~d & ~po);
      chk("R6 pad_pd", pad_pd, pe & ~d & po);
      rd_reg(2'd0, rd);
      chk("R3 readback", rd, (d & l) | (~d & pi));
    end

    // R4 synchroniser depth
    wr_reg(2'd1, 8'h00);
    pad_in = 8'h00; settle();
    pad_in = 8'h81;
    @(negedge clk);
    rd_reg(2'd0, rd); chk("R4 one edge", rd, 8'h00);
    chk("R4 one edge spi_in", {4'd0, spi_in}, 8'h00);
    @(negedge clk);
    rd_reg(2'd0, rd); chk("R4 two edges", rd, 8'h81);
    chk("R4 two edges spi_in", {4'd0, spi_in}, 8'h08);

    // R7 transmit override, R10 no pull on forced output
    wr_reg(2'd1, 8'h00); wr_reg(2'd0, 8'hFF);
    wr_reg(2'd2, 8'hFF); wr_reg(2'd3, 8'h00);
    uart_tx_en = 2'b11; uart_txd = 2'b10;
    #1;
    chk("R7 tx oe", pad_oe & 8'h0A, 8'h0A);
    chk("R7 tx out", pad_out & 8'h0A, 8'h08);
    chk("R10 forced out no pull", pad_pu & 8'h0A, 8'h00);
    uart_tx_en = 2'b00;

    // R8 receive override, R10 pull on forced input
    wr_reg(2'd1, 8'hFF);
    uart_rx_en = 2'b11;
    pad_in = 8'h04;
    settle();
    chk("R8 rx oe", pad_oe & 8'h05, 8'h00);
    chk("R8 rxd", {6'd0, uart_rxd}, 8'h02);
    chk("R10 forced in pull", pad_pu & 8'h05, 8'h05);
    uart_rx_en = 2'b01;
    #1;
    chk("R8 rx ch1 released", pad_oe & 8'h05, 8'h04);
    uart_rx_en = 2'b00;

    // R9 SPI takeover against a full-output direction mask
    wr_reg(2'd0, 8'h00);
    spi_en = 1'b1; spi_oe = 4'b0110; spi_out = 4'b0100;
    pad_in = 8'h90;
    settle();
    chk("R9 spi oe", pad_oe, 8'h6F);
    chk("R9 spi out", pad_out, 8'h40);
    chk("R9 spi_in", {4'd0, spi_in}, 8'h09);
    chk("R10 spi input pull", pad_pu, 8'h90);
    spi_en = 1'b0;
    #1;
    chk("R5 spi released", pad_oe, 8'hFF);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule